// File: doc/BRIEF.md
# Trace RAM Circular Sink

The sink takes a stream of 32-bit trace words on a valid/ready input and writes them into an on-chip, word-organised RAM that is used as a ring. Software sets the ring with two bounds registers. The low bound is the first slot. The high bound is the address of the last slot. A write pointer shows where the next word lands. Each time a word lands in the last slot, the pointer returns to the low bound and a sticky wrap bit is set. Without stop-on-wrap, capture keeps going and overwrites the oldest words. With stop-on-wrap, capture halts after the word that fills the last slot.

Software reaches the block through a small 32-bit register port with a single access per cycle. The port holds a control/status word, the bounds, the write pointer, a read pointer and a data window. Each read of the data window returns the word at the read pointer and steps the read pointer on around the ring.

Every accepted word waits one cycle in a staging register before it reaches the RAM. For this reason, shutting the block down is a handshake. Software clears the enable bit, the staged word drains, and only then does the empty flag rise.

Top module: `trace_ram_sink`

## Requirements
- R1: After reset the registers read as follows. Control (offset 0x000) reads 0x0000_0008, with only the empty flag set. Low bound (0x010) reads 0x1000. High bound (0x018) reads 0x10FC. Write pointer (0x020) reads 0x1000. Read pointer (0x028) reads 0x1000. These values hold with the default parameters: 64 words based at 0x1000.
- R2: A write to the low bound keeps the value with its low 4 bits cleared, clamped to the range 0x1000..0x10F0. A write to the high bound keeps the value with its low 2 bits cleared, clamped to the range 0x1000..0x10FC. A readback returns the value actually kept.
- R3: `tr_ready` is 1 exactly when control bit 0 (run) and bit 1 (enable) are both 1 and capture is not halted by stop-on-wrap. Each word accepted on a valid/ready handshake is stored at the write pointer, and the write pointer then advances by 4.
- R4: When a word is stored at the high-bound address, the write pointer reloads to the low bound and bit 0 of the write-pointer register (the wrap bit) becomes 1. The pointer value is the register with bit 0 masked off.
- R5: The wrap bit is sticky. Only a software write to the write-pointer register (0x020) clears it. That write also loads the pointer with the written value, low 2 bits cleared, clamped to 0x1000..0x10FC.
- R6: With control bit 14 (stop-on-wrap) set, no word is accepted after the word stored at the high bound. `tr_ready` stays 0 until the wrap bit is cleared.
- R7: With stop-on-wrap clear, capture continues past the high bound and overwrites the oldest words, starting from the low bound.
- R8: After software clears enable, `tr_ready` is 0 from the next cycle. A word accepted in the cycle of that write is still stored. Control bit 3 (empty) is 1 once no accepted word remains unstored.
- R9: Writes to the low bound, high bound and write pointer have no effect while enable is 1 or an accepted word is still unstored.
- R10: A read of the data window (0x030) returns the word at the read pointer. The read pointer then advances by 4, or reloads to the low bound if it was at or above the high bound. A write to the read pointer keeps the value with its low 2 bits cleared, clamped to 0x1000..0x10FC, and is accepted at any time.
- R11: The mode field, control bits 5:4, always reads 00, the only supported mode, whatever is written to it. The upper-half registers at 0x014, 0x01C, 0x024 and 0x02C read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tr_valid | input | 1 | Trace word offered |
| tr_data | input | 32 | Trace word |
| tr_ready | output | 1 | Sink accepts the offered word |
| reg_en | input | 1 | Register access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |

## Verification
The staging register makes it possible for a word to still be in flight while software already sees enable cleared. In that cycle, storing the staged word and a software write to the write pointer fall on the same clock edge. The bench provokes this collision in two steps. It issues the enable-clearing write in the same cycle that a trace word is accepted. On the very next cycle it writes the write pointer. The result is judged by reading the pointer and the data window afterwards. The pointer must show the advance from the staged store rather than the written value, and the staged word must be readable at the old pointer. The stop-on-wrap halt, which must act while the word for the last slot is still staged, is checked cycle by cycle against the reference model's ready.

// File: rtl/tsink_pkg.sv
package tsink_pkg;

    localparam logic [7:0] OFS_CTRL     = 8'h00;
    localparam logic [7:0] OFS_START_LO = 8'h10;
    localparam logic [7:0] OFS_START_HI = 8'h14;
    localparam logic [7:0] OFS_LIMIT_LO = 8'h18;
    localparam logic [7:0] OFS_LIMIT_HI = 8'h1C;
    localparam logic [7:0] OFS_WP_LO    = 8'h20;
    localparam logic [7:0] OFS_WP_HI    = 8'h24;
    localparam logic [7:0] OFS_RP_LO    = 8'h28;
    localparam logic [7:0] OFS_RP_HI    = 8'h2C;
    localparam logic [7:0] OFS_DATA     = 8'h30;

    localparam int CB_RUN      = 0;
    localparam int CB_ENABLE   = 1;
    localparam int CB_EMPTY    = 3;
    localparam int CB_STOPWRAP = 14;

    // Align by mask, then clamp into [lo, hi].
    function automatic logic [31:0] clip_addr(input logic [31:0] v,
                                              input logic [31:0] keep_mask,
                                              input logic [31:0] lo,
                                              input logic [31:0] hi);
        logic [31:0] a;
        a = v & keep_mask;
        if (a < lo)      a = lo;
        else if (a > hi) a = hi;
        return a;
    endfunction

    typedef struct packed {
        logic        pend_v;
        logic [31:0] pend_d;
        logic [31:0] wp;
        logic        wrap;
    } cap_state_t;

    typedef struct packed {
        logic        run;
        logic        enable;
        logic        stop_wrap;
        logic [31:0] lo_bound;
        logic [31:0] hi_bound;
        logic [31:0] rp;
    } cfg_state_t;

endpackage

// File: rtl/tsink_mem.sv
module tsink_mem #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];
endmodule

// File: rtl/tsink_cfg.sv
module tsink_cfg
    import tsink_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000,
    parameter logic [31:0] TOP_ADDR  = 32'h10FC,
    parameter logic [31:0] START_MSK = 32'hFFFF_FFF0,
    parameter logic [31:0] START_TOP = 32'h10F0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    input  logic        pend_v,
    output logic        run,
    output logic        enable,
    output logic        stop_wrap,
    output logic [31:0] lo_bound,
    output logic [31:0] hi_bound,
    output logic [31:0] rp
);
    localparam logic [31:0] WORD_MSK = 32'hFFFF_FFFC;

    cfg_state_t cfg_d, cfg_q;
    logic       lock;

    always_comb begin
        cfg_d = cfg_q;
        lock  = cfg_q.enable | pend_v;
        if (wr_stb) begin
            case (addr)
                OFS_CTRL: begin
                    cfg_d.run       = wdata[CB_RUN];
                    cfg_d.enable    = wdata[CB_ENABLE];
                    cfg_d.stop_wrap = wdata[CB_STOPWRAP];
                end
                OFS_START_LO: if (!lock) cfg_d.lo_bound = clip_addr(wdata, START_MSK, BASE_ADDR, START_TOP);
                OFS_LIMIT_LO: if (!lock) cfg_d.hi_bound = clip_addr(wdata, WORD_MSK, BASE_ADDR, TOP_ADDR);
                OFS_RP_LO:    cfg_d.rp = clip_addr(wdata, WORD_MSK, BASE_ADDR, TOP_ADDR);
                default: ;
            endcase
        end
        if (rd_stb && addr == OFS_DATA) begin
            cfg_d.rp = (cfg_q.rp >= cfg_q.hi_bound) ? cfg_q.lo_bound : cfg_q.rp + 32'd4;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.run       <= 1'b0;
            cfg_q.enable    <= 1'b0;
            cfg_q.stop_wrap <= 1'b0;
            cfg_q.lo_bound  <= BASE_ADDR;
            cfg_q.hi_bound  <= TOP_ADDR;
            cfg_q.rp        <= BASE_ADDR;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run       = cfg_q.run;
    assign enable    = cfg_q.enable;
    assign stop_wrap = cfg_q.stop_wrap;
    assign lo_bound  = cfg_q.lo_bound;
    assign hi_bound  = cfg_q.hi_bound;
    assign rp        = cfg_q.rp;

    // R9: bounds stay frozen across a cycle in which capture is enabled
    a_r9_bounds_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.enable |=> ($stable(lo_bound) && $stable(hi_bound)));

    // R2: kept bounds are aligned and inside the RAM window
    a_r2_bounds_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_bound[3:0] == 4'd0) && (hi_bound[1:0] == 2'd0) &&
        (lo_bound >= BASE_ADDR) && (hi_bound <= TOP_ADDR));

    // R10: read pointer is a legal word address
    a_r10_rp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rp[1:0] == 2'd0) && (rp >= BASE_ADDR) && (rp <= TOP_ADDR));
endmodule

// File: rtl/tsink_capture.sv
module tsink_capture
    import tsink_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR = 32'h1000,
    parameter logic [31:0] TOP_ADDR  = 32'h10FC,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             enable,
    input  logic             stop_wrap,
    input  logic [31:0]      lo_bound,
    input  logic [31:0]      hi_bound,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    output logic             in_ready,
    input  logic             wp_wr,
    input  logic [31:0]      wp_wdata,
    output logic [31:0]      wp,
    output logic             wrap,
    output logic             pend_v,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_idx,
    output logic [31:0]      mem_wdata
);
    localparam logic [31:0] WORD_MSK = 32'hFFFF_FFFC;

    cap_state_t cap_d, cap_q;
    logic       halt;
    logic       accept;
    logic       at_end;

    always_comb begin
        cap_d    = cap_q;
        at_end   = cap_q.wp >= hi_bound;
        halt     = stop_wrap & (cap_q.wrap | (cap_q.pend_v & at_end));
        in_ready = run & enable & ~halt;
        accept   = in_valid & in_ready;

        mem_we    = cap_q.pend_v;
        mem_idx   = IDX_W'((cap_q.wp - BASE_ADDR) >> 2);
        mem_wdata = cap_q.pend_d;

        if (cap_q.pend_v) begin
            if (at_end) begin
                cap_d.wp   = lo_bound;
                cap_d.wrap = 1'b1;
            end else begin
                cap_d.wp = cap_q.wp + 32'd4;
            end
        end else if (wp_wr && !enable) begin
            cap_d.wp   = clip_addr(wp_wdata, WORD_MSK, BASE_ADDR, TOP_ADDR);
            cap_d.wrap = 1'b0;
        end

        cap_d.pend_v = accept;
        if (accept) cap_d.pend_d = in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q.pend_v <= 1'b0;
            cap_q.pend_d <= '0;
            cap_q.wp     <= BASE_ADDR;
            cap_q.wrap   <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wp     = cap_q.wp;
    assign wrap   = cap_q.wrap;
    assign pend_v = cap_q.pend_v;

    // R3: ready only with run and enable
    a_r3_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (run && enable));

    // R4: a store into the last slot sets the wrap bit
    a_r4_wrap_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_v && wp >= hi_bound) |=> wrap);

    // R5: wrap bit falls only after a software pointer write
    a_r5_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrap) |-> $past(wp_wr));

    // R6: halted once wrapped under stop-on-wrap
    a_r6_halt_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wrap && wrap) |-> !in_ready);

    // R8: with enable low nothing new can be staged
    a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend_v);

    // R5: pointer is always a legal word address
    a_r5_wp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (wp[1:0] == 2'd0) && (wp >= BASE_ADDR) && (wp <= TOP_ADDR));
endmodule

// File: rtl/trace_ram_sink.sv
module trace_ram_sink
    import tsink_pkg::*;
#(
    parameter int          DEPTH       = 64,
    parameter logic [31:0] BASE_ADDR   = 32'h1000,
    parameter int          START_ALIGN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tr_valid,
    input  logic [31:0] tr_data,
    output logic        tr_ready,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int          IDX_W     = $clog2(DEPTH);
    localparam logic [31:0] TOP_ADDR  = BASE_ADDR + 32'(DEPTH * 4) - 32'd4;
    localparam logic [31:0] START_MSK = ~((32'd1 << START_ALIGN) - 32'd1);
    localparam logic [31:0] START_TOP = TOP_ADDR & START_MSK;

    logic             wr_stb, rd_stb, wp_wr;
    logic             run, enable, stop_wrap;
    logic [31:0]      lo_bound, hi_bound, rp, wp;
    logic             wrap, pend_v;
    logic             mem_we;
    logic [IDX_W-1:0] mem_widx, mem_ridx;
    logic [31:0]      mem_wdata, mem_rdata;

    assign wr_stb   = reg_en & reg_we;
    assign rd_stb   = reg_en & ~reg_we;
    assign wp_wr    = wr_stb & (reg_addr == OFS_WP_LO);
    assign mem_ridx = IDX_W'((rp - BASE_ADDR) >> 2);

    tsink_cfg #(
        .BASE_ADDR(BASE_ADDR), .TOP_ADDR(TOP_ADDR),
        .START_MSK(START_MSK), .START_TOP(START_TOP)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .addr(reg_addr), .wdata(reg_wdata), .pend_v(pend_v),
        .run(run), .enable(enable), .stop_wrap(stop_wrap),
        .lo_bound(lo_bound), .hi_bound(hi_bound), .rp(rp)
    );

    tsink_capture #(
        .BASE_ADDR(BASE_ADDR), .TOP_ADDR(TOP_ADDR), .IDX_W(IDX_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .run(run), .enable(enable),
        .stop_wrap(stop_wrap), .lo_bound(lo_bound), .hi_bound(hi_bound),
        .in_valid(tr_valid), .in_data(tr_data), .in_ready(tr_ready),
        .wp_wr(wp_wr), .wp_wdata(reg_wdata), .wp(wp), .wrap(wrap),
        .pend_v(pend_v), .mem_we(mem_we), .mem_idx(mem_widx),
        .mem_wdata(mem_wdata)
    );

    tsink_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .we(mem_we), .widx(mem_widx), .wdata(mem_wdata),
        .ridx(mem_ridx), .rdata(mem_rdata)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CB_RUN]      = run;
                reg_rdata[CB_ENABLE]   = enable;
                reg_rdata[CB_EMPTY]    = ~pend_v;
                reg_rdata[CB_STOPWRAP] = stop_wrap;
            end
            OFS_START_LO: reg_rdata = lo_bound;
            OFS_LIMIT_LO: reg_rdata = hi_bound;
            OFS_WP_LO:    reg_rdata = {wp[31:1], wrap};
            OFS_RP_LO:    reg_rdata = rp;
            OFS_DATA:     reg_rdata = mem_rdata;
            default:      reg_rdata = '0;
        endcase
    end

    // R8: an accepted word leaves the block non-empty for the next cycle
    a_r8_accept_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tr_valid && tr_ready) |=> !reg_rdata_empty_view);

    logic reg_rdata_empty_view;
    assign reg_rdata_empty_view = ~pend_v;

    // R11: mode field never reads anything but zero
    a_r11_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CTRL) |-> (reg_rdata[5:4] == 2'b00));
endmodule

// File: tb/trace_ram_sink_test.sv
module trace_ram_sink_test;
    localparam logic [7:0] A_CTRL = 8'h00, A_LO = 8'h10, A_HI = 8'h18,
                           A_WP = 8'h20, A_RP = 8'h28, A_DATA = 8'h30;

    logic        clk, rst_n;
    logic        tr_valid, tr_ready;
    logic [31:0] tr_data;
    logic        reg_en, reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    trace_ram_sink uut (
        .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_data(tr_data),
        .tr_ready(tr_ready), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference model
    bit          m_run, m_en, m_sow, m_pend, m_wrap;
    logic [31:0] m_pd, m_lo, m_hi, m_wp, m_rp;
    logic [31:0] m_mem [int];

    function automatic logic [31:0] clipb(logic [31:0] v, logic [31:0] m, logic [31:0] lo, logic [31:0] hi);
        logic [31:0] a = v & m;
        if (a < lo) return lo;
        if (a > hi) return hi;
        return a;
    endfunction

    function automatic bit m_ready();
        return m_run && m_en && !(m_sow && (m_wrap || (m_pend && m_wp >= m_hi)));
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a)
            A_CTRL: return (32'(m_sow) << 14) | (32'(!m_pend) << 3) | (32'(m_en) << 1) | 32'(m_run);
            A_LO:   return m_lo;
            A_HI:   return m_hi;
            A_WP:   return m_wp | 32'(m_wrap);
            A_RP:   return m_rp;
            A_DATA: return m_mem.exists(int'(m_rp)) ? m_mem[int'(m_rp)] : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_en = 0; m_sow = 0; m_pend = 0; m_wrap = 0; m_pd = 0;
            m_lo = 32'h1000; m_hi = 32'h10FC; m_wp = 32'h1000; m_rp = 32'h1000;
        end else begin
            bit acc, locked, w;
            acc    = tr_valid && m_ready();
            locked = m_en || m_pend;
            w      = reg_en && reg_we;
            if (m_pend) begin
                m_mem[int'(m_wp)] = m_pd;
                if (m_wp >= m_hi) begin m_wp = m_lo; m_wrap = 1; end
                else m_wp = m_wp + 4;
            end else if (w && reg_addr == A_WP && !m_en) begin
                m_wp = clipb(reg_wdata, 32'hFFFF_FFFC, 32'h1000, 32'h10FC);
                m_wrap = 0;
            end
            if (reg_en && !reg_we && reg_addr == A_DATA)
                m_rp = (m_rp >= m_hi) ? m_lo : m_rp + 4;
            if (w) begin
                case (reg_addr)
                    A_CTRL: begin m_run = reg_wdata[0]; m_en = reg_wdata[1]; m_sow = reg_wdata[14]; end
                    A_LO: if (!locked) m_lo = clipb(reg_wdata, 32'hFFFF_FFF0, 32'h1000, 32'h10F0);
                    A_HI: if (!locked) m_hi = clipb(reg_wdata, 32'hFFFF_FFFC, 32'h1000, 32'h10FC);
                    A_RP: m_rp = clipb(reg_wdata, 32'hFFFF_FFFC, 32'h1000, 32'h10FC);
                    default: ;
                endcase
            end
            m_pend = acc;
            if (acc) m_pd = tr_data;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // R3: cycle-by-cycle comparison of ready against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) check("R3 ready per cycle", 32'(tr_ready), 32'(m_ready()));
    end

    task automatic release_all();
        reg_en = 0; reg_we = 0; tr_valid = 0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 release_all();
    endtask

    task automatic wr_push(logic [7:0] a, logic [31:0] d, logic [31:0] word);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        tr_valid = 1; tr_data = word;
        @(posedge clk); #1 release_all();
    endtask

    task automatic rd(logic [7:0] a, string req, output logic [31:0] v);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        #1;
        v = reg_rdata;
        check(req, v, exp_rd(a));
        @(posedge clk); #1 release_all();
    endtask

    task automatic rd_lit(logic [7:0] a, logic [31:0] exp, string req);
        logic [31:0] v;
        rd(a, req, v);
        check(req, v, exp);
    endtask

    task automatic push(logic [31:0] d, output bit ok);
        @(negedge clk);
        tr_valid = 1; tr_data = d;
        #1 ok = tr_ready;
        @(posedge clk); #1 tr_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        int n_acc;
        release_all();
        reg_addr = 0; reg_wdata = 0; tr_data = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd_lit(A_CTRL, 32'h8, "R1 ctrl");
        rd_lit(A_LO, 32'h1000, "R1 lo");
        rd_lit(A_HI, 32'h10FC, "R1 hi");
        rd_lit(A_WP, 32'h1000, "R1 wp");
        rd_lit(A_RP, 32'h1000, "R1 rp");

        // R11 mode field and upper halves
        wr(A_CTRL, 32'h30);
        rd_lit(A_CTRL, 32'h8, "R11 mode");
        rd_lit(8'h14, 0, "R11 hi half"); rd_lit(8'h1C, 0, "R11 hi half");
        rd_lit(8'h24, 0, "R11 hi half"); rd_lit(8'h2C, 0, "R11 hi half");

        // R2 trimming
        wr(A_LO, 32'h123);    rd_lit(A_LO, 32'h1000, "R2 lo clamp low");
        wr(A_LO, 32'h1047);   rd_lit(A_LO, 32'h1040, "R2 lo align");
        wr(A_LO, 32'hFFFF);   rd_lit(A_LO, 32'h10F0, "R2 lo clamp high");
        wr(A_HI, 32'h1063);   rd_lit(A_HI, 32'h1060, "R2 hi align");
        wr(A_HI, 32'h20000);  rd_lit(A_HI, 32'h10FC, "R2 hi clamp");
        wr(A_HI, 32'h105E);   rd_lit(A_HI, 32'h105C, "R2 hi kept");
        wr(A_LO, 32'h1040);   rd_lit(A_LO, 32'h1040, "R2 lo kept");
        wr(A_WP, 32'h1041);   rd_lit(A_WP, 32'h1040, "R5 wp load");

        // R3 ready gating: enable without run
        wr(A_CTRL, 32'h2);
        push(32'hDEAD, ok);   check("R3 no run no ready", 32'(ok), 0);

        // R3 capture with a gap, then R10 readout
        wr(A_CTRL, 32'h3);
        push(32'hA0, ok); push(32'hA1, ok); push(32'hA2, ok);
        idle(2);
        push(32'hA3, ok); push(32'hA4, ok);
        wr(A_CTRL, 32'h0);
        idle(1);
        rd_lit(A_WP, 32'h1054, "R3 wp advance");
        wr(A_RP, 32'h1040);
        rd_lit(A_DATA, 32'hA0, "R10 data"); rd_lit(A_DATA, 32'hA1, "R10 data");
        rd_lit(A_DATA, 32'hA2, "R10 data"); rd_lit(A_DATA, 32'hA3, "R10 data");
        rd_lit(A_DATA, 32'hA4, "R10 data");

        // R9 writes ignored while enabled
        wr(A_CTRL, 32'h3);
        wr(A_LO, 32'h1000); wr(A_HI, 32'h10FC); wr(A_WP, 32'h1000);
        rd_lit(A_LO, 32'h1040, "R9 lo frozen");
        rd_lit(A_HI, 32'h105C, "R9 hi frozen");
        rd_lit(A_WP, 32'h1054, "R9 wp frozen");

        // R4 / R7 wrap and overwrite
        for (int i = 0; i < 6; i++) push(32'hB0 + 32'(i), ok);
        idle(2);
        rd_lit(A_WP, 32'h104D, "R4 wrap bit and reload");
        wr(A_CTRL, 32'h0);
        idle(1);
        wr(A_RP, 32'h1040);
        rd_lit(A_DATA, 32'hB3, "R7 overwrite oldest");
        rd_lit(A_DATA, 32'hB4, "R7 overwrite");
        rd_lit(A_DATA, 32'hB5, "R7 overwrite");
        rd_lit(A_DATA, 32'hA3, "R7 older word kept");

        // R5 sticky wrap
        wr(A_CTRL, 32'h1);
        wr(A_RP, 32'h1050);
        rd_lit(A_WP, 32'h104D, "R5 wrap sticky");
        wr(A_WP, 32'h1054);
        rd_lit(A_WP, 32'h1054, "R5 wrap cleared by wp write");

        // R8 / R9 collision: disable while a word is accepted, then wp write
        wr(A_CTRL, 32'h3);
        wr_push(A_CTRL, 32'h0, 32'hC0);
        wr(A_WP, 32'h1040);
        rd_lit(A_CTRL, 32'h8, "R8 disabled and empty");
        rd_lit(A_WP, 32'h1058, "R9 wp write lost to staged store");
        wr(A_RP, 32'h1054);
        rd_lit(A_DATA, 32'hC0, "R8 staged word stored");

        // R6 stop-on-wrap
        wr(A_WP, 32'h1054);
        wr(A_CTRL, 32'h4003);
        n_acc = 0;
        for (int i = 0; i < 6; i++) begin
            push(32'hD0 + 32'(i), ok);
            n_acc += int'(ok);
        end
        check("R6 words accepted", 32'(n_acc), 3);
        idle(2);
        rd_lit(A_WP, 32'h1041, "R6 halted at start with wrap");
        check("R6 ready low", 32'(tr_ready), 0);
        rd_lit(A_CTRL, 32'h400B, "R6 ctrl view");
        wr(A_CTRL, 32'h0);

        // R10 read pointer wrap and trimming
        wr(A_RP, 32'h105C);
        rd_lit(A_DATA, 32'hD2, "R10 data at hi bound");
        rd_lit(A_RP, 32'h1040, "R10 rp wraps");
        wr(A_RP, 32'h2003);
        rd_lit(A_RP, 32'h10FC, "R10 rp clamp");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule